// File: doc/BRIEF.md
# Fork-Join Worker Sequencer

This block is a small supervising controller that coordinates three subordinate state machines through a start/busy handshake. A single-cycle or level `tick` begins a run. The controller first launches workers A and B at the same time and holds its start requests until both workers report busy. It then waits for both of them to finish. Only then does it launch worker C. It waits for C to finish and returns to idle, ready for the next tick.

Each worker raises its busy line once it has accepted a start and lowers it when its job is complete. Every start output is decoded from the registered phase, so it changes only at clock edges. A tick that arrives while a run is in progress is dropped rather than queued. The run assumes both A and B raise busy before either of them finishes. If that does not happen, the launch phase never exits.

Top module: `fork_join_sequencer`

## Requirements
- R1: While `rst` is high at a rising clock edge, the controller enters the idle phase. From the next edge on, `phase_code` reads 0 and all three start outputs are low.
- R2: In idle (`phase_code` 0), the phase stays idle on every edge where `tick` is low. An edge with `tick` high moves it to the launch-AB phase (`phase_code` 1).
- R3: In launch-AB (`phase_code` 1), `start_a` and `start_b` are high and `start_c` is low.
- R4: Launch-AB persists until an edge where `busy_a` and `busy_b` are both high. One busy line alone does not advance it. Once both are high, it moves to join-AB (`phase_code` 2).
- R5: Join-AB (`phase_code` 2) drives no start output. It holds while either `busy_a` or `busy_b` is high. It moves to launch-C (`phase_code` 3) at the first edge where both are low, whichever worker finishes first.
- R6: In launch-C (`phase_code` 3), only `start_c` is high. The phase holds until an edge with `busy_c` high, then moves to join-C (`phase_code` 4).
- R7: Join-C (`phase_code` 4) drives no start output and holds while `busy_c` is high. It returns to idle at the first edge with `busy_c` low.
- R8: `tick` has no effect in any phase other than idle. A tick during a run never causes a fresh entry into launch-AB.
- R9: `start_c` is raised only after an edge at which both `busy_a` and `busy_b` were low. It is never raised while worker A or B is still reporting busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Run trigger, honoured only in idle |
| busy_a | input | 1 | Worker A busy indication |
| busy_b | input | 1 | Worker B busy indication |
| busy_c | input | 1 | Worker C busy indication |
| start_a | output | 1 | Start request to worker A |
| start_b | output | 1 | Start request to worker B |
| start_c | output | 1 | Start request to worker C |
| phase_code | output | 3 | Current phase: 0 idle, 1 launch-AB, 2 join-AB, 3 launch-C, 4 join-C |

## Verification
Each run is driven with a different ordering of the worker busy lines, and each ordering isolates one part of the join logic.
- Raising busy on A alone, then on B, shows that the launch waits for both workers rather than either one.
- Dropping A before B, and then B before A, shows that the join waits for the later finisher in either order.
- Holding off C's busy for several cycles shows that start_c stays raised until C acknowledges.
- Holding tick high through join-AB and join-C shows that a tick during a run is dropped.
- Idle cycles without a tick, and a reset asserted in the middle of a run, show the controller returning to its idle outputs.

// File: rtl/fjseq_pkg.sv
package fjseq_pkg;

    localparam int PHASE_W = 3;

    typedef enum logic [PHASE_W-1:0] {
        PH_IDLE      = 3'd0,
        PH_LAUNCH_AB = 3'd1,
        PH_JOIN_AB   = 3'd2,
        PH_LAUNCH_C  = 3'd3,
        PH_JOIN_C    = 3'd4
    } phase_e;

    typedef struct packed {
        logic tick;
        logic busy_a;
        logic busy_b;
        logic busy_c;
    } seq_in_t;

    typedef struct packed {
        logic go_a;
        logic go_b;
        logic go_c;
    } launch_t;

    // both forked workers have acknowledged their start
    function automatic logic pair_running(seq_in_t i);
        return i.busy_a & i.busy_b;
    endfunction

    // neither forked worker is still working
    function automatic logic pair_quiet(seq_in_t i);
        return ~(i.busy_a | i.busy_b);
    endfunction

    function automatic phase_e advance(phase_e cur, seq_in_t i);
        phase_e nxt;
        nxt = cur;
        case (cur)
            PH_IDLE:      if (i.tick)          nxt = PH_LAUNCH_AB;
            PH_LAUNCH_AB: if (pair_running(i)) nxt = PH_JOIN_AB;
            PH_JOIN_AB:   if (pair_quiet(i))   nxt = PH_LAUNCH_C;
            PH_LAUNCH_C:  if (i.busy_c)        nxt = PH_JOIN_C;
            PH_JOIN_C:    if (!i.busy_c)       nxt = PH_IDLE;
            default:                           nxt = PH_IDLE;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/fjseq_next.sv
module fjseq_next
    import fjseq_pkg::*;
(
    input  phase_e  cur,
    input  seq_in_t ins,
    output phase_e  nxt
);
    always_comb begin
        nxt = advance(cur, ins);
    end
endmodule

// File: rtl/fjseq_phase_reg.sv
module fjseq_phase_reg
    import fjseq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  phase_e nxt,
    output phase_e cur
);
    always_ff @(posedge clk) begin
        if (rst) cur <= PH_IDLE;
        else     cur <= nxt;
    end
endmodule

// File: rtl/fjseq_decode.sv
module fjseq_decode
    import fjseq_pkg::*;
(
    input  phase_e  cur,
    output launch_t go
);
    always_comb begin
        go      = '0;
        go.go_a = (cur == PH_LAUNCH_AB);
        go.go_b = (cur == PH_LAUNCH_AB);
        go.go_c = (cur == PH_LAUNCH_C);
    end
endmodule

// File: rtl/fork_join_sequencer.sv
module fork_join_sequencer
    import fjseq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic               busy_a,
    input  logic               busy_b,
    input  logic               busy_c,
    output logic               start_a,
    output logic               start_b,
    output logic               start_c,
    output logic [PHASE_W-1:0] phase_code
);
    seq_in_t ins;
    phase_e  cur_phase;
    phase_e  nxt_phase;
    launch_t go;

    assign ins = '{tick: tick, busy_a: busy_a, busy_b: busy_b, busy_c: busy_c};

    fjseq_next u_next (
        .cur (cur_phase),
        .ins (ins),
        .nxt (nxt_phase)
    );

    fjseq_phase_reg u_reg (
        .clk (clk),
        .rst (rst),
        .nxt (nxt_phase),
        .cur (cur_phase)
    );

    fjseq_decode u_dec (
        .cur (cur_phase),
        .go  (go)
    );

    assign start_a    = go.go_a;
    assign start_b    = go.go_b;
    assign start_c    = go.go_c;
    assign phase_code = cur_phase;
endmodule

// File: rtl/fjseq_checker.sv
module fjseq_checker (
    input logic       clk,
    input logic       rst,
    input logic       tick,
    input logic       busy_a,
    input logic       busy_b,
    input logic       busy_c,
    input logic       start_a,
    input logic       start_b,
    input logic       start_c,
    input logic [2:0] phase_code
);
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (phase_code == 3'd0 && !start_a && !start_b && !start_c));

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (phase_code == 3'd0 && !tick) |=> phase_code == 3'd0);

    assert_idle_go_R2: assert property (@(posedge clk) disable iff (rst)
        (phase_code == 3'd0 && tick) |=> phase_code == 3'd1);

    assert_launch_outputs_R3: assert property (@(posedge clk) disable iff (rst)
        (phase_code == 3'd1) |-> (start_a && start_b && !start_c));

    assert_launch_wait_R4: assert property (@(posedge clk) disable iff (rst)
        (phase_code == 3'd1 && !(busy_a && busy_b)) |=> phase_code == 3'd1);

    assert_launch_exit_R4: assert property (@(posedge clk) disable iff (rst)
        (phase_code == 3'd1 && busy_a && busy_b) |=> phase_code == 3'd2);

    assert_join_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (phase_code == 3'd2 && (busy_a || busy_b)) |=> phase_code == 3'd2);

    assert_join_exit_R5: assert property (@(posedge clk) disable iff (rst)
        (phase_code == 3'd2 && !busy_a && !busy_b) |=> phase_code == 3'd3);

    assert_launch_c_R6: assert property (@(posedge clk) disable iff (rst)
        (phase_code == 3'd3) |-> (start_c && !start_a && !start_b));

    assert_wait_c_R7: assert property (@(posedge clk) disable iff (rst)
        (phase_code == 3'd4 && busy_c) |=> phase_code == 3'd4);

    assert_done_c_R7: assert property (@(posedge clk) disable iff (rst)
        (phase_code == 3'd4 && !busy_c) |=> phase_code == 3'd0);

    assert_tick_dropped_R8: assert property (@(posedge clk) disable iff (rst)
        (phase_code != 3'd0 && phase_code != 3'd1) |=> phase_code != 3'd1);

    assert_c_after_join_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(start_c) |-> $past(!busy_a && !busy_b));

    assert_starts_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        start_c |-> !(start_a || start_b));
endmodule

bind fork_join_sequencer fjseq_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .busy_a     (busy_a),
    .busy_b     (busy_b),
    .busy_c     (busy_c),
    .start_a    (start_a),
    .start_b    (start_b),
    .start_c    (start_c),
    .phase_code (phase_code)
);

// File: tb/tb_fork_join_sequencer.sv
`timescale 1ns/1ps
module tb_fork_join_sequencer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       busy_a = 1'b0;
    logic       busy_b = 1'b0;
    logic       busy_c = 1'b0;
    logic       start_a, start_b, start_c;
    logic [2:0] phase_code;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    fork_join_sequencer dut (
        .clk(clk), .rst(rst), .tick(tick),
        .busy_a(busy_a), .busy_b(busy_b), .busy_c(busy_c),
        .start_a(start_a), .start_b(start_b), .start_c(start_c),
        .phase_code(phase_code)
    );

    task automatic chk(input string req, input string what, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    // expected outputs for a phase: {start_a,start_b,start_c}
    task automatic chk_phase(input string req, input int exp_phase);
        int exp_s;
        exp_s = (exp_phase == 1) ? 6 : (exp_phase == 3) ? 1 : 0;
        chk(req, "phase", int'(phase_code), exp_phase);
        chk(req, "starts", int'({start_a, start_b, start_c}), exp_s);
    endtask

    // one rising edge, then back to the falling edge for sampling/driving
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1; tick = 0; busy_a = 0; busy_b = 0; busy_c = 0;
        step(); step();
        rst = 1'b0;
        chk_phase("R1", 0);
    endtask

    task automatic t_idle_no_tick();
        for (int k = 0; k < 4; k++) begin
            step();
            chk_phase("R2", 0);
        end
    endtask

    // full run; a_first selects which forked worker finishes first
    task automatic t_run(input bit a_first, input bit tick_during_run);
        tick = 1'b1; step(); tick = tick_during_run;
        chk_phase("R2", 1);
        chk_phase("R3", 1);
        if (a_first) busy_a = 1'b1; else busy_b = 1'b1;
        step();
        chk_phase("R4", 1);             // one busy alone is not enough
        busy_a = 1'b1; busy_b = 1'b1;
        step();
        chk_phase("R4", 2);
        step();
        chk_phase("R8", 2);             // tick may be high here
        if (a_first) busy_a = 1'b0; else busy_b = 1'b0;
        step();
        chk_phase("R5", 2);             // other worker still busy
        chk("R9", "start_c while pair busy", int'(start_c), 0);
        busy_a = 1'b0; busy_b = 1'b0;
        step();
        chk_phase("R5", 3);
        for (int k = 0; k < 3; k++) begin
            step();
            chk_phase("R6", 3);          // waiting for C to acknowledge
        end
        busy_c = 1'b1;
        step();
        chk_phase("R6", 4);
        step();
        chk_phase("R7", 4);
        chk_phase("R8", 4);
        tick = 1'b0; busy_c = 1'b0;
        step();
        chk_phase("R7", 0);
        step();
        chk_phase("R2", 0);
    endtask

    task automatic t_reset_mid_run();
        tick = 1'b1; step(); tick = 1'b0;
        busy_a = 1'b1; busy_b = 1'b1; step();
        chk_phase("R4", 2);
        rst = 1'b1; step(); rst = 1'b0;
        busy_a = 1'b0; busy_b = 1'b0;
        chk_phase("R1", 0);
        step();
        chk_phase("R1", 0);
    endtask

    initial begin
        t_reset();
        t_idle_no_tick();
        t_run(1'b1, 1'b0);
        t_run(1'b0, 1'b1);
        t_reset_mid_run();
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule